// File: doc/BRIEF.md
# Configurable-Trigger Interrupt Controller

This block collects up to 32 interrupt request lines and merges them into one interrupt line for a processor. Each line has its own trigger rule, chosen from two independent bit-vectors: one picks edge or level sensing, the other picks the active sense (high/rising or low/falling). Every request input is first brought into the local clock domain. Detected events are then held in a pending latch until software removes them.

Software reaches the block through a simple 32-bit register bus that decodes a 4 KB window. Several copies may sit side by side at different base addresses. The pending latch is masked by a per-source enable vector to give the status word. The OR of that word, registered once, is the processor interrupt. A level source keeps re-arming its pending bit for as long as its input stays active. An edge event stays latched whether the source is enabled or not, until a write of one to the clear register removes it.

Top module: `irqc_top`

## Requirements
- R1: After reset the enable vector (offset 0x04) reads 0, the mode vector (0x0C) reads 0, the polarity vector (0x10) reads all ones, and `irq_o` is 0.
- R2: With mode bit 0 (level), polarity bit 0 makes the source pending while its input is 1, and polarity bit 1 makes it pending while its input is 0.
- R3: With mode bit 1 (edge), polarity bit 0 latches a pending event on a 0-to-1 input transition, and polarity bit 1 latches one on a 1-to-0 transition. A held input level does not latch a further event.
- R4: Writing the clear register (offset 0x08) removes the pending bit of every source whose data bit is 1. Bits written 0 leave their pending state unchanged. The clear register always reads 0.
- R5: A level source cleared while its input is still active remains pending. When a new event and a clear hit the same bit in the same cycle, the bit ends up set.
- R6: Offset 0x00 reads the raw pending vector and offset 0x14 reads the pending vector ANDed with the enable vector. Reads of any other offset in the window return 0.
- R7: An edge event latched while its source is disabled stays pending, whatever the enables do, until it is cleared. It shows in the status word once enabled.
- R8: `irq_o` equals the OR of all status bits as they were one clock earlier.
- R9: A request input change reaches the raw pending vector within four clock edges, through a two-stage synchroniser.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 32 | Asynchronous interrupt request lines, one per source |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 12 | Byte offset inside the 4 KB window (bits 1:0 ignored) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed offset (combinational) |
| irq_o | output | 1 | Combined registered interrupt to the processor |

## Verification
A corrupted pending bit shows at offset 0x00 on the next read. If that source is enabled, it also reaches offset 0x14 and, one edge later, `irq_o`. A wrong mode or polarity bit shows up as a pending bit set or missing within four edges of an input change, compared against a model that tracks every input step. A clear that drops a bit still driven by an active level, or one that misses a bit written 1, differs from the model on the read that follows the write.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int NSRC   = 32;
    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] OFS_RAW    = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_ENABLE = 12'h004;
    localparam logic [ADDR_W-1:0] OFS_CLEAR  = 12'h008;
    localparam logic [ADDR_W-1:0] OFS_MODE   = 12'h00C;
    localparam logic [ADDR_W-1:0] OFS_POL    = 12'h010;
    localparam logic [ADDR_W-1:0] OFS_STATUS = 12'h014;

    // {mode, polarity} picks one of four trigger rules
    typedef enum logic [1:0] {
        TRG_LVL_HIGH  = 2'b00,
        TRG_LVL_LOW   = 2'b01,
        TRG_EDGE_RISE = 2'b10,
        TRG_EDGE_FALL = 2'b11
    } trig_kind_e;
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= d_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/irqc_detect.sv
module irqc_detect
    import irqc_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lvl_i,
    input  logic [WIDTH-1:0] mode_i,
    input  logic [WIDTH-1:0] pol_i,
    output logic [WIDTH-1:0] event_o
);
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl_i;
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_src
        trig_kind_e kind;
        assign kind = trig_kind_e'({mode_i[i], pol_i[i]});

        always_comb begin
            unique case (kind)
                TRG_LVL_HIGH:  event_o[i] = lvl_i[i];
                TRG_LVL_LOW:   event_o[i] = ~lvl_i[i];
                TRG_EDGE_RISE: event_o[i] = lvl_i[i] & ~prev_q[i];
                TRG_EDGE_FALL: event_o[i] = ~lvl_i[i] & prev_q[i];
                default:       event_o[i] = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int AW    = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_i,
    input  logic             wr_i,
    input  logic [AW-1:0]    addr_i,
    input  logic [WIDTH-1:0] wdata_i,
    output logic [WIDTH-1:0] rdata_o,
    input  logic [WIDTH-1:0] event_i,
    output logic [WIDTH-1:0] pend_o,
    output logic [WIDTH-1:0] en_o,
    output logic [WIDTH-1:0] mode_o,
    output logic [WIDTH-1:0] pol_o
);
    localparam logic [AW-1:0] WORD_MASK = ~AW'(3);

    logic [AW-1:0]    word_addr;
    logic             wr_en, wr_mode, wr_pol, wr_clr;
    logic [WIDTH-1:0] clr_bits;

    assign word_addr = addr_i & WORD_MASK;
    assign wr_en   = sel_i & wr_i & (word_addr == OFS_ENABLE);
    assign wr_clr  = sel_i & wr_i & (word_addr == OFS_CLEAR);
    assign wr_mode = sel_i & wr_i & (word_addr == OFS_MODE);
    assign wr_pol  = sel_i & wr_i & (word_addr == OFS_POL);
    assign clr_bits = wr_clr ? wdata_i : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_o   <= '0;
            mode_o <= '0;
            pol_o  <= '1;
            pend_o <= '0;
        end else begin
            if (wr_en)   en_o   <= wdata_i;
            if (wr_mode) mode_o <= wdata_i;
            if (wr_pol)  pol_o  <= wdata_i;
            // a new event outranks a clear on the same bit
            pend_o <= (pend_o & ~clr_bits) | event_i;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (sel_i && !wr_i) begin
            unique case (word_addr)
                OFS_RAW:    rdata_o = pend_o;
                OFS_ENABLE: rdata_o = en_o;
                OFS_MODE:   rdata_o = mode_o;
                OFS_POL:    rdata_o = pol_o;
                OFS_STATUS: rdata_o = pend_o & en_o;
                default:    rdata_o = '0;
            endcase
        end
    end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int NUM_SRC   = NSRC,
    parameter int BUS_AW    = ADDR_W,
    parameter int SYNC_STGS = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_SRC-1:0]  req_i,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [BUS_AW-1:0]   bus_addr,
    input  logic [NUM_SRC-1:0]  bus_wdata,
    output logic [NUM_SRC-1:0]  bus_rdata,
    output logic                irq_o
);
    logic [NUM_SRC-1:0] req_sync, src_event, pend_q, en_q, mode_q, pol_q;

    irqc_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STGS)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(req_i), .q_o(req_sync)
    );

    irqc_detect #(.WIDTH(NUM_SRC)) u_detect (
        .clk(clk), .rst_n(rst_n), .lvl_i(req_sync),
        .mode_i(mode_q), .pol_i(pol_q), .event_o(src_event)
    );

    irqc_regs #(.WIDTH(NUM_SRC), .AW(BUS_AW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .sel_i(bus_sel), .wr_i(bus_wr), .addr_i(bus_addr),
        .wdata_i(bus_wdata), .rdata_o(bus_rdata),
        .event_i(src_event), .pend_o(pend_q), .en_o(en_q),
        .mode_o(mode_q), .pol_o(pol_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= |(pend_q & en_q);
    end
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk
    import irqc_pkg::*;
#(
    parameter int W  = 32,
    parameter int AW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_sel,
    input logic          bus_wr,
    input logic [AW-1:0] bus_addr,
    input logic [W-1:0]  bus_wdata,
    input logic [W-1:0]  pend,
    input logic [W-1:0]  en,
    input logic [W-1:0]  pol,
    input logic [W-1:0]  ev,
    input logic          irq_o
);
    logic [W-1:0] clr_req;
    assign clr_req = (bus_sel && bus_wr && (bus_addr[AW-1:2] == OFS_CLEAR[AW-1:2]))
                     ? bus_wdata : '0;

    a_r1_reset_cfg: assert property (@(posedge clk) $rose(rst_n) |-> (en == '0 && pol == '1 && !irq_o));

    a_r4_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend & $past(clr_req & ~ev)) == '0));

    a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend & $past(ev)) == $past(ev)));

    a_r7_pend_held: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend & $past(pend & ~clr_req)) == $past(pend & ~clr_req)));

    a_r8_irq_registered: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == $past(|(pend & en))));
endmodule

bind irqc_top irqc_chk #(.W(NUM_SRC), .AW(BUS_AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pend(pend_q),
    .en(en_q), .pol(pol_q), .ev(src_event), .irq_o(irq_o)
);

// File: tb/tb_irqc_top.sv
`timescale 1ns/1ps
module tb_irqc_top;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [31:0] req = '0;
    logic        sel = 0, wr = 0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0, fails = 0;
    logic [31:0] m_pend, m_en, m_mode, m_pol, m_req;

    always #4 clk = ~clk;

    irqc_top dut (.clk(clk), .rst_n(rst_n), .req_i(req), .bus_sel(sel), .bus_wr(wr),
                  .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq));

    function automatic logic [31:0] lvl_act(logic [31:0] v, logic [31:0] md, logic [31:0] pl);
        return ~md & (v ^ pl);
    endfunction

    function automatic logic [31:0] edge_ev(logic [31:0] o, logic [31:0] n,
                                             logic [31:0] md, logic [31:0] pl);
        return md & ((~pl & ~o & n) | (pl & o & ~n));
    endfunction

    task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp);
        end
    endtask

    task automatic wait_n(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic bwrite(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        sel = 1; wr = 1; addr = a; wdata = d;
        @(negedge clk);
        sel = 0; wr = 0;
    endtask

    task automatic bread(logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        sel = 1; wr = 0; addr = a;
        #1 d = rdata;
        sel = 0;
    endtask

    task automatic check_all(string r);
        logic [31:0] v;
        bread(12'h000, v); chk({r, " R6 raw"}, v, m_pend);
        bread(12'h014, v); chk({r, " R6 status"}, v, m_pend & m_en);
        wait_n(1);
        chk({r, " R8 irq"}, {31'b0, irq}, {31'b0, |(m_pend & m_en)});
    endtask

    task automatic set_req(logic [31:0] n);
        @(negedge clk);
        m_pend = m_pend | edge_ev(m_req, n, m_mode, m_pol) | lvl_act(n, m_mode, m_pol);
        req = n; m_req = n;
        wait_n(5);
    endtask

    task automatic do_clear(logic [31:0] c);
        bwrite(12'h008, c);
        m_pend = (m_pend & ~c) | lvl_act(m_req, m_mode, m_pol);
        wait_n(2);
    endtask

    initial begin
        #(8.0 * 150000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd1234));
        wait_n(3);
        rst_n = 1;
        @(negedge clk);
        chk("R1 irq", {31'b0, irq}, 32'b0);
        bread(12'h004, v); chk("R1 enable", v, 32'h0);
        bread(12'h00C, v); chk("R1 mode", v, 32'h0);
        bread(12'h010, v); chk("R1 polarity", v, 32'hFFFF_FFFF);

        // all active-high level, then flush
        m_en = 0; m_mode = 0; m_pol = 0; m_req = 0;
        bwrite(12'h010, 32'h0);
        wait_n(4);
        bwrite(12'h008, 32'hFFFF_FFFF);
        wait_n(2);
        m_pend = 0;
        check_all("R4 flush");
        bread(12'h008, v); chk("R4 clear reads 0", v, 32'h0);
        bread(12'h018, v); chk("R6 unmapped 0x018", v, 32'h0);
        bread(12'hFFC, v); chk("R6 unmapped 0xFFC", v, 32'h0);

        // R2 / R9: level high on bit 0, latency
        @(negedge clk); req = 32'h1; m_req = 32'h1;
        wait_n(4);
        bread(12'h000, v); chk("R9 latency", v & 32'h1, 32'h1);
        m_pend = 32'h1;
        // R5: clear while still asserted
        do_clear(32'h1);
        check_all("R5 relatch");
        set_req(32'h0);
        do_clear(32'h1);
        check_all("R2 level released");
        // R2 low level on bit 1
        bwrite(12'h010, 32'h2); m_pol = 32'h2;
        m_pend |= lvl_act(m_req, m_mode, m_pol);
        wait_n(4);
        check_all("R2 level low");
        // R3 edges: bits 4 rising, 5 falling; disabled (R7)
        bwrite(12'h00C, 32'h30); m_mode = 32'h30;
        bwrite(12'h010, 32'h22); m_pol = 32'h22;
        do_clear(32'hFFFF_FFFF);
        set_req(32'h30);
        check_all("R3 rise");
        chk("R3 rise bit4", m_pend & 32'h30, 32'h10);
        set_req(32'h30);
        do_clear(32'h10);
        check_all("R3 held no event");
        set_req(32'h00);
        check_all("R3 fall");
        bwrite(12'h004, 32'h0); wait_n(3);
        check_all("R7 disabled held");
        bwrite(12'h004, 32'h20); m_en = 32'h20; wait_n(3);
        check_all("R7 enabled shows");
        do_clear(32'h0);
        check_all("R4 zero write no effect");
        do_clear(32'h20);
        check_all("R4 edge cleared");

        // random phase
        for (int it = 0; it < 400; it++) begin
            int act;
            act = $urandom_range(0, 4);
            case (act)
                0, 1: set_req($urandom());
                2: do_clear($urandom());
                3: begin
                    v = $urandom(); bwrite(12'h004, v); m_en = v; wait_n(2);
                end
                default: begin
                    v = $urandom();
                    if ($urandom_range(0, 1) == 0) begin bwrite(12'h00C, v); m_mode = v; end
                    else begin bwrite(12'h010, v); m_pol = v; end
                    m_pend |= lvl_act(m_req, m_mode, m_pol);
                    wait_n(3);
                end
            endcase
            check_all("R2 R3 random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule